// File: doc/BRIEF.md
# Debug Host Read Sequencer with Handshake

This block is the host end of a single-wire debug link. It takes one command at a time and sends a frame that begins with an 8-bit opcode. Each bit travels as one request to a separate bit-cell engine. After the last bit of the frame, the line is left to the target. The block then watches the sensed line level for the target's acknowledge pulse instead of waiting out a fixed worst-case delay.

Three kinds of command are supported. A byte read sends the opcode and a 16-bit address. After the acknowledge, it clocks in a 16-bit word and returns one byte of it, chosen by the address parity. A write sends the opcode, the address and a 16-bit data word. A control command sends the opcode alone. Writes and control commands are complete once the acknowledge pulse has ended.

There is no time limit on the acknowledge. An abort input lets the owner give up on a target that will never answer, for example one that has gone into a stop state. The abort returns the sequencer to idle and raises an error flag.

Top module: `dbg_rd_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `done`, `err` and `bit_req` are 0.
- R2: A read (`cmd_kind`=0) is sent as a 24-bit frame, most significant bit first: the opcode, then the address. After the acknowledge it makes exactly 16 receive requests (`bit_wr`=0), taking the word most significant bit first.
- R3: A write (`cmd_kind`=1) is sent as a 40-bit frame: opcode, then address, then `cmd_wdata`. A control command (`cmd_kind`=2 or 3) sends only the 8 opcode bits. Neither makes any receive request.
- R4: The acknowledge is recognised only after `line_in` has been sampled low on at least ACK_MIN (default 12) consecutive cycles where `tick` is high. A shorter low run is ignored and restarts the count. While the line is low, no bit request is made.
- R5: After a qualifying low run, the sequencer goes on only at the first `tick` sample that finds `line_in` high again.
- R6: There is no upper limit on the wait for the acknowledge. The sequencer stays busy and quiet for any length of time until the acknowledge arrives.
- R7: For a read, an even address returns word[15:8] and an odd address returns word[7:0]. A write or control command reports `rd_byte`=0x00.
- R8: `done` is a single-cycle pulse, with `rd_byte` valid in the same cycle. It is raised in the cycle after the last receive bit is accepted (read), or after the acknowledge ends (write or control). It is raised only once per command.
- R9: `abort` during the acknowledge wait returns the block to idle with `err`=1 and no `done`. `abort` at any other time is ignored. `err` clears when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when `cmd_ready` is high |
| cmd_kind | input | 2 | 0 read byte, 1 write, 2 or 3 control |
| cmd_opcode | input | 8 | Command opcode, sent first |
| cmd_addr | input | 16 | Target address |
| cmd_wdata | input | 16 | Write data word |
| cmd_ready | output | 1 | Idle and able to take a command |
| abort | input | 1 | Give up the acknowledge wait |
| tick | input | 1 | Serial clock enable for line sampling |
| line_in | input | 1 | Sensed, already synchronised level of the debug line |
| bit_req | output | 1 | Request to the bit-cell engine, held until `bit_ack` |
| bit_wr | output | 1 | 1 = send `bit_out`, 0 = receive a bit |
| bit_out | output | 1 | Bit to send |
| bit_ack | input | 1 | Bit-cell engine finished the requested bit |
| bit_in | input | 1 | Received bit, valid with `bit_ack` |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Result byte |
| err | output | 1 | Last command was aborted |

## Verification
If the bit counter is wrong, the frame captured at the bit-engine port has the wrong length or the wrong content. This shows as soon as the last bit is served. A fault in the low-run counter shows at the ports in one of two ways: a short pulse is accepted, so receive requests start during the wait, or a 12-tick pulse is never taken, so the run hangs. A wrong parity choice or word assembly shows as a mismatched `rd_byte` on the `done` pulse. A wrong error-flag state is visible on `err` one cycle after the abort, or one cycle after the next command is accepted.

// File: rtl/dbg_rd_pkg.sv
package dbg_rd_pkg;

    localparam int OP_W    = 8;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_CTRL  = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV
    } seq_state_e;

    typedef struct packed {
        cmd_kind_e kind;
        logic      odd;
    } cmd_ctx_t;

    function automatic cmd_kind_e decode_kind(input logic [1:0] raw);
        case (raw)
            2'd0:    return CMD_READ;
            2'd1:    return CMD_WRITE;
            default: return CMD_CTRL;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] frame_bits(input cmd_kind_e k);
        case (k)
            CMD_READ:  return CNT_W'(OP_W + ADDR_W);
            CMD_WRITE: return CNT_W'(FRAME_W);
            default:   return CNT_W'(OP_W);
        endcase
    endfunction

    // big-endian word: even address takes the upper byte
    function automatic logic [7:0] pick_byte(input logic [DATA_W-1:0] w, input logic odd);
        return odd ? w[7:0] : w[DATA_W-1 -: 8];
    endfunction

endpackage

// File: rtl/dbg_shreg.sv
module dbg_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[W-2:0], sin};
    end

endmodule

// File: rtl/dbg_ack_det.sv
module dbg_ack_det #(
    parameter int ACK_MIN = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic line_in,
    output logic ack_end
);

    localparam int CW = $clog2(ACK_MIN + 1);

    logic [CW-1:0] low_run;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            low_run <= '0;
            seen    <= 1'b0;
        end else if (tick) begin
            if (!line_in) begin
                if (low_run != CW'(ACK_MIN))
                    low_run <= low_run + 1'b1;
                if (low_run == CW'(ACK_MIN - 1))
                    seen <= 1'b1;
            end else begin
                low_run <= '0;
            end
        end
    end

    assign ack_end = en && tick && line_in && seen;

    // R4: a qualifying pulse is only latched while the line is sampled low
    assert_seen_on_low_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(seen) |-> ($past(!line_in) && $past(tick)));

endmodule

// File: rtl/dbg_rd_seq.sv
module dbg_rd_seq
    import dbg_rd_pkg::*;
#(
    parameter int ACK_MIN = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [OP_W-1:0]   cmd_opcode,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    input  logic              abort,
    input  logic              tick,
    input  logic              line_in,
    output logic              bit_req,
    output logic              bit_wr,
    output logic              bit_out,
    input  logic              bit_ack,
    input  logic              bit_in,
    output logic              done,
    output logic [7:0]        rd_byte,
    output logic              err
);

    seq_state_e          state;
    cmd_ctx_t            ctx;
    logic [CNT_W-1:0]    bits_left;
    logic [FRAME_W-1:0]  tx_q;
    logic [DATA_W-1:0]   rx_q;
    logic [DATA_W-1:0]   rx_word;
    logic                accept;
    logic                ack_end;
    logic                unused_bits;

    assign accept    = (state == ST_IDLE) && cmd_valid;
    assign cmd_ready = (state == ST_IDLE);
    assign bit_req   = (state == ST_SEND) || (state == ST_RECV);
    assign bit_wr    = (state == ST_SEND);
    assign bit_out   = tx_q[FRAME_W-1];
    assign rx_word   = {rx_q[DATA_W-2:0], bit_in};
    assign unused_bits = ^{tx_q[FRAME_W-2:0], rx_q[DATA_W-1]};

    dbg_shreg #(.W(FRAME_W)) tx_sr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val ({cmd_opcode, cmd_addr, cmd_wdata}),
        .shift    ((state == ST_SEND) && bit_ack),
        .sin      (1'b0),
        .q        (tx_q)
    );

    dbg_shreg #(.W(DATA_W)) rx_sr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val ('0),
        .shift    ((state == ST_RECV) && bit_ack),
        .sin      (bit_in),
        .q        (rx_q)
    );

    dbg_ack_det #(.ACK_MIN(ACK_MIN)) ack_i (
        .clk     (clk),
        .rst     (rst),
        .en      (state == ST_WAIT),
        .tick    (tick),
        .line_in (line_in),
        .ack_end (ack_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctx       <= '{kind: CMD_READ, odd: 1'b0};
            bits_left <= '0;
            done      <= 1'b0;
            rd_byte   <= '0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        ctx.kind  <= decode_kind(cmd_kind);
                        ctx.odd   <= cmd_addr[0];
                        bits_left <= frame_bits(decode_kind(cmd_kind));
                        err       <= 1'b0;
                        state     <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (bit_ack) begin
                        bits_left <= bits_left - 1'b1;
                        if (bits_left == CNT_W'(1))
                            state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (abort) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end else if (ack_end) begin
                        if (ctx.kind == CMD_READ) begin
                            bits_left <= CNT_W'(DATA_W);
                            state     <= ST_RECV;
                        end else begin
                            rd_byte <= '0;
                            done    <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                end
                ST_RECV: begin
                    if (bit_ack) begin
                        bits_left <= bits_left - 1'b1;
                        if (bits_left == CNT_W'(1)) begin
                            rd_byte <= pick_byte(rx_word, ctx.odd);
                            done    <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready);

    assert_abort_err_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && abort) |=> (err && cmd_ready && !done));

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && cmd_valid) |=> !err);

    assert_recv_only_read_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECV) |-> (ctx.kind == CMD_READ));

    assert_wait_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !line_in) |=> !done);

endmodule

// File: tb/dbg_rd_seq_tb.sv
module dbg_rd_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic [7:0]  cmd_opcode = 8'h00;
    logic [15:0] cmd_addr = 16'h0000;
    logic [15:0] cmd_wdata = 16'h0000;
    logic        cmd_ready;
    logic        abort = 1'b0;
    logic        tick = 1'b0;
    logic        line_in = 1'b1;
    logic        bit_req;
    logic        bit_wr;
    logic        bit_out;
    logic        bit_ack = 1'b0;
    logic        bit_in = 1'b0;
    logic        done;
    logic [7:0]  rd_byte;
    logic        err;

    int          total = 0;
    int          bad = 0;
    int          mon_cnt = 0;
    int          tdiv = 0;
    logic [39:0] tx_cap = '0;
    int          tx_cnt = 0;
    int          rx_acks = 0;
    int          rx_idx = 15;
    logic [15:0] rx_word = '0;
    logic [7:0]  exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbg_rd_seq dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ready(cmd_ready), .abort(abort), .tick(tick), .line_in(line_in),
        .bit_req(bit_req), .bit_wr(bit_wr), .bit_out(bit_out), .bit_ack(bit_ack),
        .bit_in(bit_in), .done(done), .rd_byte(rd_byte), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // serial clock enable: one cycle in three
    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick = (tdiv == 0);
    end

    // target-side bit-cell model: serves each request after one cycle
    always @(negedge clk) begin
        if (bit_ack) begin
            bit_ack = 1'b0;
        end else if (bit_req && !rst) begin
            bit_ack = 1'b1;
            if (bit_wr) begin
                tx_cap = {tx_cap[38:0], bit_out};
                tx_cnt++;
            end else begin
                bit_in = rx_word[rx_idx[3:0]];
                rx_idx--;
                rx_acks++;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            mon_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 done without command", {56'd0, rd_byte}, 64'd0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_byte == e, "R7 result byte", {56'd0, rd_byte}, {56'd0, e});
            end
        end
    end

    task automatic issue(input logic [1:0] k, input logic [7:0] op, input logic [15:0] a,
                         input logic [15:0] wd, input logic [15:0] word, input int nbits,
                         input string req);
        logic [39:0] frame;
        frame   = {op, a, wd};
        rx_word = word;
        rx_idx  = 15;
        rx_acks = 0;
        tx_cnt  = 0;
        tx_cap  = '0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_opcode = op; cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(err == 1'b0, "R9 err cleared on accept", {63'd0, err}, 64'd0);
        while (tx_cnt < nbits) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(tx_cap == (frame >> (40 - nbits)), req, {24'd0, tx_cap}, {24'd0, frame >> (40 - nbits)});
        chk(tx_cnt == nbits && !bit_req && !cmd_ready, {req, " frame length / waiting"},
            64'(tx_cnt), 64'(nbits));
    endtask

    task automatic low_ticks(input int n);
        int c;
        c = 0;
        @(negedge clk);
        line_in = 1'b0;
        while (c < n) begin
            @(posedge clk);
            if (tick) c++;
        end
        @(negedge clk);
        line_in = 1'b1;
    endtask

    task automatic wait_done();
        int start;
        start = mon_cnt;
        while (mon_cnt == start) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R8 done is one cycle", {63'd0, done}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 ready after reset", {63'd0, cmd_ready}, 64'd1);
        chk(done == 1'b0, "R1 done low after reset", {63'd0, done}, 64'd0);
        chk(err == 1'b0, "R1 err low after reset", {63'd0, err}, 64'd0);
        chk(bit_req == 1'b0, "R1 no bit request after reset", {63'd0, bit_req}, 64'd0);

        // R2 R7: read, even address, minimum-length acknowledge
        issue(2'd0, 8'hE0, 16'h1234, 16'h0000, 16'hA55A, 24, "R2 read frame");
        exp_q.push_back(8'hA5);
        low_ticks(12);
        wait_done();
        chk(rx_acks == 16, "R2 sixteen receive bits", 64'(rx_acks), 64'd16);

        // R7: read, odd address
        issue(2'd0, 8'hE0, 16'h8001, 16'h0000, 16'h3CC7, 24, "R2 read frame odd");
        exp_q.push_back(8'hC7);
        low_ticks(12);
        wait_done();

        // R3: write frame, no receive bits
        issue(2'd1, 8'hC0, 16'hBEEF, 16'h5AA5, 16'hFFFF, 40, "R3 write frame");
        exp_q.push_back(8'h00);
        low_ticks(14);
        wait_done();
        chk(rx_acks == 0, "R3 write makes no receive request", 64'(rx_acks), 64'd0);

        // R3: control command, opcode only (kind 3 also control)
        issue(2'd3, 8'h90, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8, "R3 control frame");
        exp_q.push_back(8'h00);
        low_ticks(12);
        wait_done();
        chk(rx_acks == 0, "R3 control makes no receive request", 64'(rx_acks), 64'd0);

        // R4: an 11-tick low is ignored, a 12-tick low is accepted
        issue(2'd0, 8'hE4, 16'h0042, 16'h0000, 16'h7E81, 24, "R2 read frame short");
        low_ticks(11);
        repeat (30) @(negedge clk);
        chk(!bit_req && !cmd_ready && rx_acks == 0, "R4 short low ignored",
            64'(rx_acks), 64'd0);
        exp_q.push_back(8'h7E);
        low_ticks(12);
        wait_done();

        // R5: no progress while the line stays low past the minimum
        issue(2'd0, 8'hE0, 16'h0003, 16'h0000, 16'h1299, 24, "R2 read frame long low");
        exp_q.push_back(8'h99);
        begin
            int c;
            c = 0;
            @(negedge clk);
            line_in = 1'b0;
            while (c < 20) begin
                @(posedge clk);
                if (tick) c++;
            end
            @(negedge clk);
            chk(!bit_req && rx_acks == 0, "R5 waits for line high", 64'(rx_acks), 64'd0);
            line_in = 1'b1;
        end
        wait_done();

        // R6: long silent wait before the acknowledge
        issue(2'd1, 8'hC4, 16'h0100, 16'h0001, 16'h0000, 40, "R3 write frame slow");
        repeat (3000) @(negedge clk);
        chk(!cmd_ready && !done && !bit_req, "R6 still waiting", {63'd0, cmd_ready}, 64'd0);
        exp_q.push_back(8'h00);
        low_ticks(12);
        wait_done();

        // R9: abort during the wait
        issue(2'd0, 8'hE0, 16'h2222, 16'h0000, 16'hFFFF, 24, "R2 read frame abort");
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(err == 1'b1, "R9 err after abort", {63'd0, err}, 64'd1);
        chk(cmd_ready == 1'b1, "R9 idle after abort", {63'd0, cmd_ready}, 64'd1);
        repeat (10) @(negedge clk);
        chk(mon_cnt == 7, "R9 no done after abort", 64'(mon_cnt), 64'd7);

        // R9: abort during sending is ignored; err clears on the new command
        fork
            begin
                repeat (3) @(negedge clk);
                abort = 1'b1;
                repeat (4) @(negedge clk);
                abort = 1'b0;
            end
            issue(2'd0, 8'hE8, 16'h4444, 16'h0000, 16'hD00D, 24, "R9 abort while sending ignored");
        join
        chk(err == 1'b0, "R9 err stays low", {63'd0, err}, 64'd0);
        exp_q.push_back(8'hD0);
        low_ticks(12);
        wait_done();

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all results seen", 64'(exp_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule